// File: doc/BRIEF.md
# GPIO Port Register Block with Configuration Lock

This block is the register side of a 16-pin general-purpose I/O port. A simple word-wide bus reaches its registers: an address, a write strobe with write data, and a read strobe with read data. Software uses them to pick each pin's role (input, output, alternate function or analog), its drive type, slew speed, pull resistor and alternate-function number. It also writes the output levels, either as a whole word or through an atomic set/clear word, and reads the synchronized pin levels.

A key sequence freezes the configuration of chosen pins until the next reset. Three writes to the lock register carry the same pin mask, with the key bit at 1, then 0, then 1. A read of the lock register then completes the sequence. Output data stays writable on locked pins. The block drives configuration vectors and output levels toward pad logic. The pads themselves lie outside it.

Top module: `gpio_port_ctrl`

Register word addresses: 0 mode, 1 drive type, 2 speed, 3 pull, 4 input (read-only), 5 output data, 6 set/clear (write-only), 7 lock, 8 alternate function pins 0-7, 9 alternate function pins 8-15. Reads are combinational: `bus_rdata` shows the addressed register while `bus_rd` is high and is zero otherwise.

## Requirements
- R1: After a synchronous active-low reset, every configuration register, the output data, the lock bits and the key bit are zero, so every pin is an input with no pull, and all drive outputs read zero.
- R2: A write to mode (2 bits per pin at bit 2p: 00 input, 01 output, 10 alternate, 11 analog), drive type (bit p: 0 push-pull, 1 open-drain), speed (2 bits at 2p: 00 low to 11 very high) or pull (2 bits at 2p: 00 none, 01 up, 10 down) updates the matching drive output on the next clock edge and reads back unchanged.
- R3: Alternate-function numbers are 4 bits per pin. Pins 0-7 live at bit 4p of the low register (address 8) and pins 8-15 at bit 4(p-8) of the high register (address 9). The combined output `pin_af_o` carries pin p at bit 4p.
- R4: In the set/clear register (address 6), a 1 in bit n sets output bit n and a 1 in bit n+16 clears it. Zero bits leave output bits unchanged, and the register reads as zero.
- R5: When one set/clear write has both the set bit and the clear bit of a pin at 1, the pin ends up set.
- R6: A write to output data (address 5) loads the low 16 bits onto `pin_out_o` on the next edge and reads back unchanged.
- R7: Each pin input passes through two synchronizer flops and then the input register. A level change is visible at address 4 after exactly three clock edges, and writes to address 4 have no effect.
- R8: Three lock writes carrying the same mask, with bit 16 at 1, then 0, then 1, followed by a read of address 7, set the key (bit 16) and load the mask into lock bits 15:0. Both read back from address 7.
- R9: A lock write whose mask or key value does not fit the next step breaks an unfinished sequence. So does a write to any other register before the completing read. The sequencer then returns to idle, and the key and lock bits stay zero.
- R10: Once the key is set, writes to mode, type, speed, pull and alternate-function fields of locked pins are ignored, while the same writes still update unlocked pins.
- R11: Once the key is set, the lock register ignores further writes until reset, while output data and set/clear writes keep working on locked pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_mode_o | output | 32 | Mode, 2 bits per pin |
| pin_type_o | output | 16 | Drive type, 1 bit per pin |
| pin_speed_o | output | 32 | Slew speed, 2 bits per pin |
| pin_pull_o | output | 32 | Pull selection, 2 bits per pin |
| pin_af_o | output | 64 | Alternate-function number, 4 bits per pin |
| pin_out_o | output | 16 | Output data levels |

## Verification
A wrong lock state shows up at the ports in one of two ways. A frozen pin changes on a drive output one edge after a configuration write, or an unlocked pin fails to change there. Address 7 also shows the wrong key or mask on the first read. A sequencer that wrongly stays armed after a stray write shows only later, when a lone lock read sets the key. The bench therefore reads address 7 right after each broken sequence. A fault in the synchronizer path shows as input data arriving one edge early or late. The bench samples it on the second and third edges after a change.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and the register address map of the GPIO port.
// Assumes a 16-pin port and a 32-bit bus word; the lock key sits at bit PINS.
package gpio_port_pkg;
    localparam int PINS    = 16;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int MODE_FW = 2;
    localparam int AF_FW   = 4;
    localparam int AF_HALF = PINS / 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_MODE   = 4'd0,
        RA_TYPE   = 4'd1,
        RA_SPEED  = 4'd2,
        RA_PULL   = 4'd3,
        RA_IN     = 4'd4,
        RA_OUT    = 4'd5,
        RA_SETCLR = 4'd6,
        RA_LOCK   = 4'd7,
        RA_AFLO   = 4'd8,
        RA_AFHI   = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_ONE,
        LK_ZERO,
        LK_ARMED
    } lock_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer followed by the input data register.
// Assumes pin levels are asynchronous; latency is three edges.
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] in_q
);
    logic [W-1:0] s1_q, s2_q;
    logic [1:0]   seen_q;

    // Shift pin levels through both synchronizer stages into the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            in_q <= '0;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            in_q <= s2_q;
        end
    end

    // Count edges since reset, saturating, so the latency check starts clean.
    always_ff @(posedge clk) begin
        if (!rst_n)              seen_q <= '0;
        else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end

    // R7: register holds the pin level sampled three edges earlier.
    a_r7_in_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3) |-> (in_q == $past(pin_i, 3)));
endmodule

// File: rtl/gpio_cfg_field.sv
// Module: one per-pin configuration register of FW bits per pin.
// Assumes lock_i bits only rise; a locked pin's field ignores writes.
module gpio_cfg_field #(
    parameter int NP = 16,
    parameter int FW = 2,
    localparam int TW = NP * FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [TW-1:0] wdata_i,
    input  logic [NP-1:0] lock_i,
    output logic [TW-1:0] q
);
    for (genvar p = 0; p < NP; p++) begin : g_pin
        // Load this pin's field on a write unless the pin is locked.
        always_ff @(posedge clk) begin
            if (!rst_n)                  q[p*FW +: FW] <= '0;
            else if (wr_i && !lock_i[p]) q[p*FW +: FW] <= wdata_i[p*FW +: FW];
        end

        // R10: a locked pin's field does not move.
        a_r10_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
            lock_i[p] |=> (q[p*FW +: FW] == $past(q[p*FW +: FW])));
    end
endmodule

// File: rtl/gpio_lock_seq.sv
// Module: key-sequence lock. Three matching lock writes with key 1,0,1 and a
// lock read set the key and pin lock bits. Any other write breaks it.
// Assumes one bus access per cycle; once keyed, it is inert until reset.
module gpio_lock_seq
    import gpio_port_pkg::*;
#(
    parameter int NP = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_any_i,
    input  logic          wr_lock_i,
    input  logic          rd_lock_i,
    input  logic [NP:0]   wdata_i,
    output logic [NP-1:0] lock_q,
    output logic          key_q
);
    lock_state_e   st_q;
    logic [NP-1:0] mask_q;
    logic          key_bit, same_mask;

    assign key_bit   = wdata_i[NP];
    assign same_mask = (wdata_i[NP-1:0] == mask_q);

    // Step the key sequence; complete on the lock read, abort on a wrong write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= LK_IDLE;
            mask_q <= '0;
            lock_q <= '0;
            key_q  <= 1'b0;
        end else if (!key_q) begin
            unique case (st_q)
                LK_IDLE: if (wr_lock_i && key_bit) begin
                    st_q   <= LK_ONE;
                    mask_q <= wdata_i[NP-1:0];
                end
                LK_ONE: begin
                    if (wr_lock_i && !key_bit && same_mask) st_q <= LK_ZERO;
                    else if (wr_any_i)                      st_q <= LK_IDLE;
                end
                LK_ZERO: begin
                    if (wr_lock_i && key_bit && same_mask) st_q <= LK_ARMED;
                    else if (wr_any_i)                     st_q <= LK_IDLE;
                end
                LK_ARMED: begin
                    if (wr_any_i) st_q <= LK_IDLE;
                    else if (rd_lock_i) begin
                        key_q  <= 1'b1;
                        lock_q <= mask_q;
                        st_q   <= LK_IDLE;
                    end
                end
                default: st_q <= LK_IDLE;
            endcase
        end
    end

    // R8: the key only rises on a lock read in the armed step.
    a_r8_key_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_q) |-> $past(st_q == LK_ARMED && rd_lock_i && !wr_any_i));

    // R11: key and lock bits are frozen once set.
    a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        key_q |=> (key_q && $stable(lock_q)));

    // R9: lock bits never appear without the key.
    a_r9_no_lock_without_key: assert property (@(posedge clk) disable iff (!rst_n)
        !key_q |-> (lock_q == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
// Module: GPIO port register block. Decodes the word bus, holds configuration,
// output data and lock state, and returns combinational read data.
// Assumes at most one of bus_wr / bus_rd per cycle; read strobes are one cycle.
module gpio_port_ctrl
    import gpio_port_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [WORD_W-1:0]       bus_wdata,
    input  logic                    bus_rd,
    output logic [WORD_W-1:0]       bus_rdata,
    input  logic [PINS-1:0]         pin_in,
    output logic [PINS*MODE_FW-1:0] pin_mode_o,
    output logic [PINS-1:0]         pin_type_o,
    output logic [PINS*MODE_FW-1:0] pin_speed_o,
    output logic [PINS*MODE_FW-1:0] pin_pull_o,
    output logic [PINS*AF_FW-1:0]   pin_af_o,
    output logic [PINS-1:0]         pin_out_o
);
    localparam int AFW = AF_HALF * AF_FW;

    logic            we_mode, we_type, we_speed, we_pull, we_out, we_sc;
    logic            we_lock, we_aflo, we_afhi, re_lock;
    logic [PINS-1:0] lock_bits, in_data, odr_q, sc_set, sc_clr;
    logic            key;

    // Address decode of write and read strobes.
    always_comb begin
        we_mode  = bus_wr && (bus_addr == RA_MODE);
        we_type  = bus_wr && (bus_addr == RA_TYPE);
        we_speed = bus_wr && (bus_addr == RA_SPEED);
        we_pull  = bus_wr && (bus_addr == RA_PULL);
        we_out   = bus_wr && (bus_addr == RA_OUT);
        we_sc    = bus_wr && (bus_addr == RA_SETCLR);
        we_lock  = bus_wr && (bus_addr == RA_LOCK);
        we_aflo  = bus_wr && (bus_addr == RA_AFLO);
        we_afhi  = bus_wr && (bus_addr == RA_AFHI);
        re_lock  = bus_rd && (bus_addr == RA_LOCK);
    end

    gpio_cfg_field #(.NP(PINS), .FW(MODE_FW)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_i(we_mode), .wdata_i(bus_wdata),
        .lock_i(lock_bits), .q(pin_mode_o));
    gpio_cfg_field #(.NP(PINS), .FW(1)) u_type (
        .clk(clk), .rst_n(rst_n), .wr_i(we_type), .wdata_i(bus_wdata[PINS-1:0]),
        .lock_i(lock_bits), .q(pin_type_o));
    gpio_cfg_field #(.NP(PINS), .FW(MODE_FW)) u_speed (
        .clk(clk), .rst_n(rst_n), .wr_i(we_speed), .wdata_i(bus_wdata),
        .lock_i(lock_bits), .q(pin_speed_o));
    gpio_cfg_field #(.NP(PINS), .FW(MODE_FW)) u_pull (
        .clk(clk), .rst_n(rst_n), .wr_i(we_pull), .wdata_i(bus_wdata),
        .lock_i(lock_bits), .q(pin_pull_o));
    gpio_cfg_field #(.NP(AF_HALF), .FW(AF_FW)) u_af_lo (
        .clk(clk), .rst_n(rst_n), .wr_i(we_aflo), .wdata_i(bus_wdata[AFW-1:0]),
        .lock_i(lock_bits[AF_HALF-1:0]), .q(pin_af_o[AFW-1:0]));
    gpio_cfg_field #(.NP(AF_HALF), .FW(AF_FW)) u_af_hi (
        .clk(clk), .rst_n(rst_n), .wr_i(we_afhi), .wdata_i(bus_wdata[AFW-1:0]),
        .lock_i(lock_bits[PINS-1:AF_HALF]), .q(pin_af_o[2*AFW-1:AFW]));

    gpio_lock_seq #(.NP(PINS)) u_lock (
        .clk(clk), .rst_n(rst_n), .wr_any_i(bus_wr), .wr_lock_i(we_lock),
        .rd_lock_i(re_lock), .wdata_i(bus_wdata[PINS:0]),
        .lock_q(lock_bits), .key_q(key));

    gpio_in_sync #(.W(PINS)) u_in (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .in_q(in_data));

    assign sc_set = bus_wdata[PINS-1:0];
    assign sc_clr = bus_wdata[2*PINS-1:PINS];

    // Output data: whole-word load or atomic set/clear with set winning.
    always_ff @(posedge clk) begin
        if (!rst_n)      odr_q <= '0;
        else if (we_out) odr_q <= bus_wdata[PINS-1:0];
        else if (we_sc)  odr_q <= (odr_q & ~sc_clr) | sc_set;
    end
    assign pin_out_o = odr_q;

    // Read data multiplexer; write-only and unused addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                RA_MODE:  bus_rdata = pin_mode_o;
                RA_TYPE:  bus_rdata[PINS-1:0] = pin_type_o;
                RA_SPEED: bus_rdata = pin_speed_o;
                RA_PULL:  bus_rdata = pin_pull_o;
                RA_IN:    bus_rdata[PINS-1:0] = in_data;
                RA_OUT:   bus_rdata[PINS-1:0] = odr_q;
                RA_LOCK:  bus_rdata[PINS:0] = {key, lock_bits};
                RA_AFLO:  bus_rdata = pin_af_o[AFW-1:0];
                RA_AFHI:  bus_rdata = pin_af_o[2*AFW-1:AFW];
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R5: every set bit of a set/clear write ends up high.
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        we_sc |=> ((pin_out_o & $past(sc_set)) == $past(sc_set)));

    // R4: clear-only bits of a set/clear write end up low.
    a_r4_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        we_sc |=> ((pin_out_o & $past(sc_clr & ~sc_set)) == '0));

    // R4: untouched bits keep their level across a set/clear write.
    a_r4_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        we_sc |=> (((pin_out_o ^ $past(pin_out_o)) & ~$past(sc_clr | sc_set)) == '0));

    // R11: output data still follows a word write after the key is set.
    a_r11_out_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (we_out && key) |=> (pin_out_o == $past(bus_wdata[PINS-1:0])));
endmodule

// File: tb/gpio_port_ctrl_bench.sv
// Bench: directed corner cases plus seeded random register traffic, checked
// against a reference model built from the requirements.
module gpio_port_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [31:0] pin_mode_o, pin_speed_o, pin_pull_o;
    logic [15:0] pin_type_o, pin_out_o;
    logic [63:0] pin_af_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Reference model state.
    logic [31:0] m_mode, m_speed, m_pull, m_aflo, m_afhi;
    logic [15:0] m_type, m_odr, m_lock, m_mask;
    logic        m_key;
    int          m_step;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_mode_o(pin_mode_o), .pin_type_o(pin_type_o),
        .pin_speed_o(pin_speed_o), .pin_pull_o(pin_pull_o),
        .pin_af_o(pin_af_o), .pin_out_o(pin_out_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] spread(input logic [15:0] m, input int fw, input int base);
        logic [31:0] r = '0;
        for (int i = 0; i < 32 / fw; i++)
            for (int b = 0; b < fw; b++)
                if (base + i < 16) r[i*fw + b] = m[base + i];
        return r;
    endfunction

    function automatic logic [31:0] keep(input logic [31:0] old, input logic [31:0] d,
                                         input logic [31:0] lk);
        return (old & lk) | (d & ~lk);
    endfunction

    task automatic model_reset();
        m_mode = '0; m_speed = '0; m_pull = '0; m_aflo = '0; m_afhi = '0;
        m_type = '0; m_odr = '0; m_lock = '0; m_mask = '0; m_key = 0; m_step = 0;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        case (a)
            4'd0: m_mode  = keep(m_mode,  d, spread(m_lock, 2, 0));
            4'd1: m_type  = keep({16'h0, m_type}, d, {16'h0, m_lock})[15:0] & 16'hFFFF;
            4'd2: m_speed = keep(m_speed, d, spread(m_lock, 2, 0));
            4'd3: m_pull  = keep(m_pull,  d, spread(m_lock, 2, 0));
            4'd5: m_odr   = d[15:0];
            4'd6: m_odr   = (m_odr & ~d[31:16]) | d[15:0];
            4'd8: m_aflo  = keep(m_aflo, d, spread(m_lock, 4, 0));
            4'd9: m_afhi  = keep(m_afhi, d, spread(m_lock, 4, 8));
            default: ;
        endcase
        if (!m_key) begin
            case (m_step)
                0: if (a == 4'd7 && d[16]) begin m_step = 1; m_mask = d[15:0]; end
                1: m_step = (a == 4'd7 && !d[16] && d[15:0] == m_mask) ? 2 : 0;
                2: m_step = (a == 4'd7 &&  d[16] && d[15:0] == m_mask) ? 3 : 0;
                default: m_step = 0;
            endcase
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return m_mode;
            4'd1: return {16'h0, m_type};
            4'd2: return m_speed;
            4'd3: return m_pull;
            4'd4: return {16'h0, pin_in};
            4'd5: return {16'h0, m_odr};
            4'd7: return {15'h0, m_key, m_lock};
            4'd8: return m_aflo;
            4'd9: return m_afhi;
            default: return '0;
        endcase
    endfunction

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        if (a == 4'd7 && !m_key && m_step == 3) begin
            m_key = 1'b1; m_lock = m_mask; m_step = 0;
        end else if (a == 4'd7) m_step = (m_key ? 0 : m_step);
    endtask

    task automatic chk_read(input string req, input logic [3:0] a);
        logic [31:0] exp, got;
        exp = model_read(a);
        do_read(a, got);
        chk(req, {32'h0, got}, {32'h0, exp});
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " mode"},  {32'h0, pin_mode_o},  {32'h0, m_mode});
        chk({req, " type"},  {48'h0, pin_type_o},  {48'h0, m_type});
        chk({req, " speed"}, {32'h0, pin_speed_o}, {32'h0, m_speed});
        chk({req, " pull"},  {32'h0, pin_pull_o},  {32'h0, m_pull});
        chk({req, " af"},    pin_af_o,             {m_afhi, m_aflo});
        chk({req, " out"},   {48'h0, pin_out_o},   {48'h0, m_odr});
    endtask

    task automatic random_phase(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [3:0] a;
            a = 4'($urandom_range(0, 9));
            if (a == 4'd7 && ($urandom_range(0, 3) != 0)) a = 4'd6;
            do_write(a, $urandom);
            chk_outputs(req);
            chk_read(req, 4'($urandom_range(0, 9)));
        end
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state on every output and readable register.
        chk_outputs("R1 reset");
        for (int a = 0; a < 10; a++) chk_read("R1 reset read", 4'(a));

        // R2: configuration writes show on drive outputs one edge later.
        do_write(4'd0, 32'h1B1B_E4E4); chk({"R2"}, {32'h0, pin_mode_o}, 64'h1B1B_E4E4);
        do_write(4'd1, 32'hFFFF_00FF); chk({"R2"}, {48'h0, pin_type_o}, 64'h00FF);
        do_write(4'd2, 32'hC3C3_0F0F); chk({"R2"}, {32'h0, pin_speed_o}, 64'hC3C3_0F0F);
        do_write(4'd3, 32'h5555_AAAA); chk({"R2"}, {32'h0, pin_pull_o}, 64'h5555_AAAA);
        chk_read("R2 mode read", 4'd0);
        chk_read("R2 type read", 4'd1);

        // R3: alternate-function halves map pin p to nibble p of pin_af_o.
        do_write(4'd8, 32'h7654_3210);
        do_write(4'd9, 32'hFEDC_BA98);
        chk("R3 af layout", pin_af_o, 64'hFEDC_BA98_7654_3210);
        chk("R3 pin 9 nibble", {60'h0, pin_af_o[39:36]}, 64'h9);
        chk_read("R3 af high read", 4'd9);

        // R6: whole-word output load.
        do_write(4'd5, 32'hFFFF_A5A5);
        chk("R6 out load", {48'h0, pin_out_o}, 64'hA5A5);
        chk_read("R6 out read", 4'd5);

        // R4: set low half, clear high half, untouched bits kept, reads zero.
        do_write(4'd6, 32'hF000_000F);
        chk("R4 set/clear", {48'h0, pin_out_o}, 64'h05AF);
        chk_read("R4 setclr reads zero", 4'd6);

        // R5: set and clear of the same pin leaves it set.
        do_write(4'd6, 32'h0300_0100);
        chk("R5 set wins", {48'h0, pin_out_o}, 64'h05AF & ~64'h0200 | 64'h0100);

        // R7: three-edge input latency and a write to the input register.
        @(negedge clk);
        pin_in = 16'hBEEF; bus_addr = 4'd4; bus_rd = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R7 not yet after two edges", {32'h0, bus_rdata}, 64'h0);
        @(posedge clk); #1;
        chk("R7 visible after three edges", {32'h0, bus_rdata}, 64'hBEEF);
        bus_rd = 1'b0;
        do_write(4'd4, 32'h0000_1234);
        chk_read("R7 input write ignored", 4'd4);

        // R9: mask mismatch, key mismatch and a foreign write break the sequence.
        do_write(4'd7, 32'h0001_00F0); do_write(4'd7, 32'h0000_00F1);
        do_write(4'd7, 32'h0001_00F0); chk_read("R9 mask mismatch", 4'd7);
        do_write(4'd7, 32'h0001_00F0); do_write(4'd7, 32'h0001_00F0);
        do_write(4'd7, 32'h0001_00F0); chk_read("R9 key mismatch", 4'd7);
        do_write(4'd7, 32'h0001_00F0); do_write(4'd7, 32'h0000_00F0);
        do_write(4'd7, 32'h0001_00F0); do_write(4'd5, 32'h0000_0001);
        chk_read("R9 foreign write", 4'd7);
        chk_read("R9 lone read after break", 4'd7);
        chk("R9 key still clear", {63'h0, m_key}, 64'h0);

        // Random traffic before the lock.
        random_phase(150, "R2 random");

        // R8: full sequence locks pins 4-7.
        do_write(4'd7, 32'h0001_00F0); do_write(4'd7, 32'h0000_00F0);
        do_write(4'd7, 32'h0001_00F0);
        do_read(4'd7, rd);
        do_read(4'd7, rd);
        chk("R8 key and mask", {32'h0, rd}, 64'h0001_00F0);

        // R10: locked pins keep configuration, unlocked pins follow.
        do_write(4'd0, 32'hFFFF_FFFF);
        do_write(4'd8, 32'hAAAA_AAAA);
        do_write(4'd1, 32'h0000_FFFF);
        chk_outputs("R10 locked pins");
        chk("R10 pin 0 mode updated", {62'h0, pin_mode_o[1:0]}, 64'h3);

        // R11: lock register frozen, output data still writable on pin 5.
        do_write(4'd7, 32'h0001_FFFF); do_write(4'd7, 32'h0000_FFFF);
        do_write(4'd7, 32'h0001_FFFF);
        do_read(4'd7, rd);
        chk("R11 lock frozen", {32'h0, rd}, 64'h0001_00F0);
        do_write(4'd6, 32'h0000_0020);
        chk("R11 set on locked pin", {63'h0, pin_out_o[5]}, 64'h1);
        do_write(4'd6, 32'h0020_0000);
        chk("R11 clear on locked pin", {63'h0, pin_out_o[5]}, 64'h0);

        random_phase(150, "R10 random");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule